// File: doc/BRIEF.md
# Translation Lookaside Cache with Global-Aware Invalidation

This block keeps a small fully associative set of completed page translations. Each lookup presents a logical page number, the address space (user or supervisor) and the access direction. In the same cycle the block answers with exactly one of four outcomes: a hit, a protection fault, a miss, or a request to record the page's modified state. On a hit it returns the physical page number, the two-bit cache mode, the supervisor-only and write-protect flags, the global flag and the two user page attribute bits. The attribute bits leave the block on their own pins, so that any external bus transfer caused by the access can carry them.

An external table walker loads entries through a fill port. The fill port takes the low twelve descriptor bits exactly as the walker reads them from memory. A fill whose tag is already present rewrites that entry in place. Any other fill takes the next slot in round-robin order.

Four single-cycle invalidation commands are provided. Two of them, the non-global-only variants, leave entries marked global untouched. The page size (4 KB or 8 KB) is a parameter, and it sets how many logical address bits make up the tag.

Top module: `tlc_top`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss.
- R2: After a fill, a lookup with the same page number and space hits and returns the filled physical page number. It also returns the attributes, decoded from fill_desc as follows: global = bit 10, user attributes = bits 9:8, supervisor-only = bit 7, cache mode = bits 6:5, modified = bit 4, write-protect = bit 2. The same page number in the other space misses.
- R3: A user-space lookup that matches a supervisor-only entry raises fault and not hit. A supervisor-space lookup of the same entry hits.
- R4: A write lookup that matches a write-protected entry raises fault in either space. A read of that entry hits.
- R5: A write lookup that matches a permitted entry whose modified bit is clear raises upd_req and not hit. Once the entry is refilled with modified set, the same write hits.
- R6: Flush op 0 invalidates every entry, global ones included.
- R7: Flush op 1 invalidates every entry whose global bit is clear, and keeps every global entry.
- R8: Flush op 2 invalidates only the entry that matches fl_vpn and fl_super, whether or not it is global. Entries in the other space are not affected.
- R9: Flush op 3 invalidates the matching entry only if its global bit is clear.
- R10: A fill whose page number and space match a valid entry overwrites that entry. Later lookups return the new contents, and no extra slot is consumed.
- R11: Fills of new tags use slots in round-robin order. After reset, a fill beyond the capacity evicts the entry filled first, and all the others remain.
- R12: When lk_valid is high, exactly one of hit, fault, miss and upd_req is high. When lk_valid is low, all four are low. The user attribute outputs are zero unless hit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Logical page number to look up |
| lk_super | input | 1 | 1 = supervisor space, 0 = user space |
| lk_write | input | 1 | 1 = write access |
| hit | output | 1 | Permitted translation found |
| fault | output | 1 | Match found but the access is not permitted |
| miss | output | 1 | No matching entry |
| upd_req | output | 1 | Permitted write to a page whose modified bit is clear |
| out_ppn | output | PPN_W | Physical page number of the matching entry |
| out_cmode | output | 2 | Cache mode: 0 write-through, 1 copy-back, 2 uncached serialized, 3 uncached |
| out_upa | output | 2 | User page attributes {bit9, bit8}, gated by hit |
| out_global | output | 1 | Global flag of the matching entry |
| out_sprot | output | 1 | Supervisor-only flag of the matching entry |
| out_wprot | output | 1 | Write-protect flag of the matching entry |
| fill_valid | input | 1 | Load an entry |
| fill_vpn | input | VPN_W | Page number of the fill |
| fill_super | input | 1 | Space of the fill |
| fill_ppn | input | PPN_W | Physical page number of the fill |
| fill_desc | input | 12 | Low descriptor bits carrying the attributes |
| fl_valid | input | 1 | Invalidate command |
| fl_op | input | 2 | 0 all, 1 all non-global, 2 one page, 3 one page if non-global |
| fl_vpn | input | VPN_W | Page number for ops 2 and 3 |
| fl_super | input | 1 | Space for ops 2 and 3 |

## Verification
The bench builds the block with 8 KB pages, which gives a 19-bit tag and page number and so exercises the non-default page-size variant. It keeps the default depth of 16 entries, a power of two, which selects the wrapping round-robin pointer. With that depth, a seventeen-fill sweep reaches the first eviction, and the in-place refill can be told apart from a fresh allocation. Every outcome class is driven, along with each of the four invalidation commands against a mix of global and non-global entries in both spaces.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

   typedef enum logic [1:0] {
      CM_WTHRU = 2'd0,
      CM_CBACK = 2'd1,
      CM_NCSER = 2'd2,
      CM_NCACH = 2'd3
   } cmode_e;

   typedef enum logic [1:0] {
      FL_ALL     = 2'd0,
      FL_NONGLOB = 2'd1,
      FL_PAGE    = 2'd2,
      FL_PAGE_NG = 2'd3
   } flop_e;

   typedef struct packed {
      logic       glob;
      logic [1:0] upa;
      logic       sprot;
      cmode_e     cmode;
      logic       modf;
      logic       wprot;
   } attr_t;

   localparam int DESC_W = 12;

   function automatic attr_t decode_desc(input logic [DESC_W-1:0] d);
      attr_t a;
      a.glob  = d[10];
      a.upa   = d[9:8];
      a.sprot = d[7];
      a.cmode = cmode_e'(d[6:5]);
      a.modf  = d[4];
      a.wprot = d[2];
      return a;
   endfunction

endpackage

// File: rtl/tlc_victim.sv
module tlc_victim #(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [IDX_W-1:0] ptr
);
   localparam bit IS_POW2 = (ENTRIES & (ENTRIES - 1)) == 0;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   logic [IDX_W-1:0] ptr_q, ptr_d;

   generate
      if (IS_POW2) begin : g_wrap
         assign ptr_d = ptr_q + 1'b1;
      end else begin : g_cmp
         assign ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   ptr_q <= '0;
      else if (adv) ptr_q <= ptr_d;
   end

   assign ptr = ptr_q;

   // R11: each allocation moves the pointer on; idle cycles hold it
   a_r11_rr_moves: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (ptr != $past(ptr)));
   a_r11_rr_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(ptr));
   a_r11_rr_range: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= LAST);

endmodule

// File: rtl/tlc_store.sv
module tlc_store
   import tlc_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   parameter int IDX_W   = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   // lookup
   input  logic [VPN_W-1:0]   lk_vpn,
   input  logic               lk_super,
   output logic [ENTRIES-1:0] lk_match,
   output logic [PPN_W-1:0]   rd_ppn,
   output attr_t              rd_attr,
   // fill
   input  logic               fill_en,
   input  logic [IDX_W-1:0]   fill_idx,
   input  logic [VPN_W-1:0]   fill_vpn,
   input  logic               fill_super,
   input  logic [PPN_W-1:0]   fill_ppn,
   input  attr_t              fill_attr,
   output logic               fill_found,
   output logic [IDX_W-1:0]   fill_found_idx,
   // invalidate
   input  logic               fl_en,
   input  flop_e              fl_op,
   input  logic [VPN_W-1:0]   fl_vpn,
   input  logic               fl_super
);
   logic [ENTRIES-1:0] vld_q;
   logic [ENTRIES-1:0] sup_q;
   logic [ENTRIES-1:0] glob_vec;
   logic [ENTRIES-1:0] fi_match;
   logic [ENTRIES-1:0] fl_match;
   logic [ENTRIES-1:0] kill;
   logic [VPN_W-1:0]   vpn_q  [ENTRIES];
   logic [PPN_W-1:0]   ppn_q  [ENTRIES];
   attr_t              attr_q [ENTRIES];

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
         logic wr_here;
         assign wr_here     = fill_en && (fill_idx == IDX_W'(e));
         assign glob_vec[e] = attr_q[e].glob;
         assign lk_match[e] = vld_q[e] && (sup_q[e] == lk_super)   && (vpn_q[e] == lk_vpn);
         assign fi_match[e] = vld_q[e] && (sup_q[e] == fill_super) && (vpn_q[e] == fill_vpn);
         assign fl_match[e] = vld_q[e] && (sup_q[e] == fl_super)   && (vpn_q[e] == fl_vpn);

         always_comb begin
            kill[e] = 1'b0;
            if (fl_en) begin
               unique case (fl_op)
                  FL_ALL:     kill[e] = 1'b1;
                  FL_NONGLOB: kill[e] = !attr_q[e].glob;
                  FL_PAGE:    kill[e] = fl_match[e];
                  FL_PAGE_NG: kill[e] = fl_match[e] && !attr_q[e].glob;
                  default:    kill[e] = 1'b0;
               endcase
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n)       vld_q[e] <= 1'b0;
            else if (wr_here) vld_q[e] <= 1'b1;
            else if (kill[e]) vld_q[e] <= 1'b0;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sup_q[e]  <= 1'b0;
               vpn_q[e]  <= '0;
               ppn_q[e]  <= '0;
               attr_q[e] <= '0;
            end else if (wr_here) begin
               sup_q[e]  <= fill_super;
               vpn_q[e]  <= fill_vpn;
               ppn_q[e]  <= fill_ppn;
               attr_q[e] <= fill_attr;
            end
         end
      end
   endgenerate

   // lowest matching slot wins on both paths
   always_comb begin
      rd_ppn  = '0;
      rd_attr = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (lk_match[i]) begin
            rd_ppn  = ppn_q[i];
            rd_attr = attr_q[i];
         end
      end
   end

   always_comb begin
      fill_found     = 1'b0;
      fill_found_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (fi_match[i]) begin
            fill_found     = 1'b1;
            fill_found_idx = IDX_W'(i);
         end
      end
   end

   // R10: in-place refill keeps tags unique
   a_r10_one_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match));
   // R6: full invalidate empties the array
   a_r6_all_gone: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_en && fl_op == FL_ALL && !fill_en) |=> (vld_q == '0));
   // R7: non-global invalidate keeps exactly the global entries
   a_r7_glob_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_en && fl_op == FL_NONGLOB && !fill_en) |=> (vld_q == ($past(vld_q) & $past(glob_vec))));
   // R9: page non-global invalidate never drops a global entry
   a_r9_page_ng: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_en && fl_op == FL_PAGE_NG && !fill_en) |=> ((vld_q & glob_vec) == ($past(vld_q) & $past(glob_vec))));
   // R2: a fill always leaves a valid entry behind
   a_r2_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> (vld_q != '0));

endmodule

// File: rtl/tlc_check.sv
module tlc_check
   import tlc_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  lk_valid,
   input  logic  lk_super,
   input  logic  lk_write,
   input  logic  any_match,
   input  attr_t attr,
   output logic  hit,
   output logic  fault,
   output logic  miss,
   output logic  upd_req
);
   logic sup_viol, wr_viol, viol, needs_mod;

   assign sup_viol  = attr.sprot && !lk_super;
   assign wr_viol   = attr.wprot && lk_write;
   assign viol      = sup_viol || wr_viol;
   assign needs_mod = lk_write && !attr.modf;

   always_comb begin
      hit     = 1'b0;
      fault   = 1'b0;
      miss    = 1'b0;
      upd_req = 1'b0;
      if (lk_valid) begin
         if (!any_match)     miss    = 1'b1;
         else if (viol)      fault   = 1'b1;
         else if (needs_mod) upd_req = 1'b1;
         else                hit     = 1'b1;
      end
   end

   // R12: one outcome per lookup, none when idle
   a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> ($countones({hit, fault, miss, upd_req}) == 1));
   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> !(hit || fault || miss || upd_req));
   // R3: user space never hits a supervisor-only page
   a_r3_user_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (hit || upd_req) |-> !(attr.sprot && !lk_super));
   // R4: writes to protected pages fault
   a_r4_wp_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && any_match && lk_write && attr.wprot) |-> fault);
   // R5: a write hit only on an already modified page
   a_r5_mod_needed: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && lk_write) |-> attr.modf);

endmodule

// File: rtl/tlc_top.sv
module tlc_top
   import tlc_pkg::*;
#(
   parameter int VA_W    = 32,
   parameter int PA_W    = 32,
   parameter bit PAGE_8K = 1'b0,
   parameter int ENTRIES = 16,
   localparam int PG_SHIFT = PAGE_8K ? 13 : 12,
   localparam int VPN_W    = VA_W - PG_SHIFT,
   localparam int PPN_W    = PA_W - PG_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic              lk_super,
   input  logic              lk_write,
   output logic              hit,
   output logic              fault,
   output logic              miss,
   output logic              upd_req,
   output logic [PPN_W-1:0]  out_ppn,
   output logic [1:0]        out_cmode,
   output logic [1:0]        out_upa,
   output logic              out_global,
   output logic              out_sprot,
   output logic              out_wprot,
   input  logic              fill_valid,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic              fill_super,
   input  logic [PPN_W-1:0]  fill_ppn,
   input  logic [11:0]       fill_desc,
   input  logic              fl_valid,
   input  logic [1:0]        fl_op,
   input  logic [VPN_W-1:0]  fl_vpn,
   input  logic              fl_super
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   generate
      if (ENTRIES < 2) begin : g_bad_depth
         $error("tlc_top: ENTRIES must be at least 2");
      end
      if (VA_W <= PG_SHIFT || PA_W <= PG_SHIFT) begin : g_bad_width
         $error("tlc_top: address widths must exceed the page offset");
      end
   endgenerate

   logic [ENTRIES-1:0] lk_match;
   logic [PPN_W-1:0]   rd_ppn;
   attr_t              rd_attr;
   logic               fill_found;
   logic [IDX_W-1:0]   fill_found_idx;
   logic [IDX_W-1:0]   rr_ptr;
   logic [IDX_W-1:0]   fill_idx;
   logic               alloc;
   attr_t              fill_attr;

   assign fill_attr = decode_desc(fill_desc);
   assign alloc     = fill_valid && !fill_found;
   assign fill_idx  = fill_found ? fill_found_idx : rr_ptr;

   tlc_store #(
      .ENTRIES (ENTRIES),
      .VPN_W   (VPN_W),
      .PPN_W   (PPN_W),
      .IDX_W   (IDX_W)
   ) u_store (
      .clk            (clk),
      .rst_n          (rst_n),
      .lk_vpn         (lk_vpn),
      .lk_super       (lk_super),
      .lk_match       (lk_match),
      .rd_ppn         (rd_ppn),
      .rd_attr        (rd_attr),
      .fill_en        (fill_valid),
      .fill_idx       (fill_idx),
      .fill_vpn       (fill_vpn),
      .fill_super     (fill_super),
      .fill_ppn       (fill_ppn),
      .fill_attr      (fill_attr),
      .fill_found     (fill_found),
      .fill_found_idx (fill_found_idx),
      .fl_en          (fl_valid),
      .fl_op          (flop_e'(fl_op)),
      .fl_vpn         (fl_vpn),
      .fl_super       (fl_super)
   );

   tlc_victim #(
      .ENTRIES (ENTRIES),
      .IDX_W   (IDX_W)
   ) u_victim (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (alloc),
      .ptr   (rr_ptr)
   );

   tlc_check u_check (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_valid  (lk_valid),
      .lk_super  (lk_super),
      .lk_write  (lk_write),
      .any_match (|lk_match),
      .attr      (rd_attr),
      .hit       (hit),
      .fault     (fault),
      .miss      (miss),
      .upd_req   (upd_req)
   );

   assign out_ppn    = rd_ppn;
   assign out_cmode  = rd_attr.cmode;
   assign out_upa    = hit ? rd_attr.upa : 2'b00;
   assign out_global = rd_attr.glob;
   assign out_sprot  = rd_attr.sprot;
   assign out_wprot  = rd_attr.wprot;

   // R12: attribute pins stay quiet off a hit
   a_r12_upa_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (out_upa == 2'b00));
   // R1: nothing matches in the cycle after reset releases
   a_r1_empty_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> (lk_match == '0));

endmodule

// File: tb/tb_tlc_top.sv
module tb_tlc_top;
   localparam int VPN_W = 19;
   localparam int PPN_W = 19;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             lk_valid = 1'b0, lk_super = 1'b0, lk_write = 1'b0;
   logic [VPN_W-1:0] lk_vpn = '0;
   logic             hit, fault, miss, upd_req;
   logic [PPN_W-1:0] out_ppn;
   logic [1:0]       out_cmode, out_upa;
   logic             out_global, out_sprot, out_wprot;
   logic             fill_valid = 1'b0, fill_super = 1'b0;
   logic [VPN_W-1:0] fill_vpn = '0;
   logic [PPN_W-1:0] fill_ppn = '0;
   logic [11:0]      fill_desc = '0;
   logic             fl_valid = 1'b0, fl_super = 1'b0;
   logic [1:0]       fl_op = '0;
   logic [VPN_W-1:0] fl_vpn = '0;

   int n_chk = 0;
   int n_bad = 0;

   localparam int HIT = 8, FLT = 4, MIS = 2, UPD = 1, NONE = 0;

   always #4 clk = ~clk;

   tlc_top #(.PAGE_8K(1'b1), .ENTRIES(16)) dut (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_super(lk_super), .lk_write(lk_write),
      .hit(hit), .fault(fault), .miss(miss), .upd_req(upd_req),
      .out_ppn(out_ppn), .out_cmode(out_cmode), .out_upa(out_upa),
      .out_global(out_global), .out_sprot(out_sprot), .out_wprot(out_wprot),
      .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_super(fill_super),
      .fill_ppn(fill_ppn), .fill_desc(fill_desc),
      .fl_valid(fl_valid), .fl_op(fl_op), .fl_vpn(fl_vpn), .fl_super(fl_super)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic fill(input int vpn, input bit sup, input int ppn, input logic [11:0] desc);
      @(negedge clk);
      fill_valid = 1'b1; fill_vpn = VPN_W'(vpn); fill_super = sup;
      fill_ppn = PPN_W'(ppn); fill_desc = desc;
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   task automatic flush(input int op, input int vpn, input bit sup);
      @(negedge clk);
      fl_valid = 1'b1; fl_op = 2'(op); fl_vpn = VPN_W'(vpn); fl_super = sup;
      @(negedge clk);
      fl_valid = 1'b0;
   endtask

   // combinational answer, sampled 1 ns after the inputs settle
   task automatic look(input string req, input int vpn, input bit sup, input bit wr,
                       input int exp_cls);
      @(negedge clk);
      lk_valid = 1'b1; lk_vpn = VPN_W'(vpn); lk_super = sup; lk_write = wr;
      #1;
      check(req, {hit, fault, miss, upd_req}, exp_cls);
   endtask

   task automatic look_end();
      lk_valid = 1'b0; lk_write = 1'b0;
   endtask

   task automatic t_reset_state();
      do_reset();
      #1;
      check("R12 idle", {hit, fault, miss, upd_req}, NONE);
      look("R1 empty", 5, 1'b0, 1'b0, MIS); look_end();
      look("R1 empty sup", 0, 1'b1, 1'b0, MIS); look_end();
   endtask

   task automatic t_fill_hit();
      // global=0 upa=10 sprot=0 cmode=01 modf=1 wprot=0
      fill(1, 1'b0, 19'h1234, 12'h230);
      look("R2 hit", 1, 1'b0, 1'b0, HIT);
      check("R2 ppn", out_ppn, 19'h1234);
      check("R2 cmode", out_cmode, 1);
      check("R2 upa", out_upa, 2);
      check("R2 glob", out_global, 0);
      look_end();
      look("R2 other space", 1, 1'b1, 1'b0, MIS);
      check("R12 upa gated", out_upa, 0);
      look_end();
   endtask

   task automatic t_protect();
      fill(2, 1'b0, 19'h22, 12'h090);  // sprot, modf
      look("R3 user fault", 2, 1'b0, 1'b0, FLT); look_end();
      fill(2, 1'b1, 19'h23, 12'h090);
      look("R3 super hit", 2, 1'b1, 1'b0, HIT);
      check("R3 sprot out", out_sprot, 1);
      look_end();
      fill(3, 1'b1, 19'h33, 12'h014);  // wprot, modf
      look("R4 write fault", 3, 1'b1, 1'b1, FLT); look_end();
      look("R4 read hit", 3, 1'b1, 1'b0, HIT);
      check("R4 wprot out", out_wprot, 1);
      look_end();
   endtask

   task automatic t_modify();
      fill(4, 1'b0, 19'h44, 12'h060);  // cmode 11, modf clear
      look("R5 write needs update", 4, 1'b0, 1'b1, UPD); look_end();
      look("R5 read hit", 4, 1'b0, 1'b0, HIT);
      check("R5 cmode", out_cmode, 3);
      look_end();
      fill(4, 1'b0, 19'h55, 12'h070);
      look("R5 write hit after refill", 4, 1'b0, 1'b1, HIT);
      check("R10 new ppn", out_ppn, 19'h55);
      look_end();
   endtask

   task automatic t_flush_all();
      fill(5, 1'b0, 19'h5, 12'h410);   // global
      flush(0, 0, 1'b0);
      look("R6 global gone", 5, 1'b0, 1'b0, MIS); look_end();
      look("R6 ng gone", 1, 1'b0, 1'b0, MIS); look_end();
   endtask

   task automatic t_flush_nonglobal();
      do_reset();
      fill(10, 1'b0, 19'hA, 12'h410);
      fill(11, 1'b0, 19'hB, 12'h010);
      flush(1, 0, 1'b0);
      look("R7 global kept", 10, 1'b0, 1'b0, HIT);
      check("R7 global flag", out_global, 1);
      look_end();
      look("R7 ng dropped", 11, 1'b0, 1'b0, MIS); look_end();
   endtask

   task automatic t_flush_page();
      fill(12, 1'b0, 19'hC, 12'h410);
      fill(13, 1'b0, 19'hD, 12'h010);
      fill(14, 1'b0, 19'hE, 12'h010);
      flush(2, 12, 1'b0);
      look("R8 global page dropped", 12, 1'b0, 1'b0, MIS); look_end();
      look("R8 neighbour kept", 13, 1'b0, 1'b0, HIT); look_end();
      flush(2, 13, 1'b1);
      look("R8 other space untouched", 13, 1'b0, 1'b0, HIT); look_end();
   endtask

   task automatic t_flush_page_ng();
      flush(3, 10, 1'b0);
      look("R9 global page kept", 10, 1'b0, 1'b0, HIT); look_end();
      flush(3, 14, 1'b0);
      look("R9 ng page dropped", 14, 1'b0, 1'b0, MIS); look_end();
   endtask

   task automatic t_round_robin();
      do_reset();
      for (int i = 0; i < 17; i++) fill(16'h100 + i, 1'b1, i + 1, 12'h010);
      look("R11 first evicted", 16'h100, 1'b1, 1'b0, MIS); look_end();
      look("R11 second kept", 16'h101, 1'b1, 1'b0, HIT);
      check("R11 second ppn", out_ppn, 2);
      look_end();
      look("R11 newest kept", 16'h110, 1'b1, 1'b0, HIT); look_end();
   endtask

   task automatic t_refill_in_place();
      do_reset();
      fill(16'h200, 1'b0, 19'h1, 12'h010);
      fill(16'h200, 1'b0, 19'h2, 12'h210);
      look("R10 refilled", 16'h200, 1'b0, 1'b0, HIT);
      check("R10 refill ppn", out_ppn, 19'h2);
      check("R10 refill upa", out_upa, 2);
      look_end();
      for (int i = 1; i < 16; i++) fill(16'h200 + i, 1'b0, 19'h40 + i, 12'h010);
      look("R10 no slot lost", 16'h200, 1'b0, 1'b0, HIT); look_end();
      look("R10 last of sixteen", 16'h20F, 1'b0, 1'b0, HIT); look_end();
      fill(16'h300, 1'b0, 19'h7, 12'h010);
      look("R11 wrap evicts slot0", 16'h200, 1'b0, 1'b0, MIS); look_end();
   endtask

   initial begin
      #(200000 * 8);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset_state();
      t_fill_hit();
      t_protect();
      t_modify();
      t_flush_all();
      t_flush_nonglobal();
      t_flush_page();
      t_flush_page_ng();
      t_round_robin();
      t_refill_in_place();
      @(negedge clk);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule